// File: doc/BRIEF.md
# Interrupt Pass-Through Routing Front End

This block sits between two special interrupt sources and a multiprocessor interrupt distribution core. It decides how each source is delivered. The first source is a cascaded legacy PIC line that arrives on external source 0. The second is a vector of host-bridge error flags, which the block folds into a single request.

Two registered control bits set the routing: a global controller enable and a pass-through select. Each bit has its own load strobe. Together they form a four-state machine:

- `ST_OFF_BYPASS` is the reset state.
- `ST_OFF_ROUTED` is disabled with pass-through cleared.
- `ST_ON_BYPASS` is enabled with pass-through set.
- `ST_ON_ROUTED` is enabled with pass-through cleared.

The transitions are:

- `T_ENABLE` and `T_DISABLE` flip the enable bit.
- `T_BYPASS_ON` and `T_BYPASS_OFF` flip the pass-through bit.
- `T_BOTH` flips both bits on the same edge.
- `T_HOLD` applies when no strobe is active.

In the disabled states, processor 0's direct pin carries only the merged error. In `ST_ON_BYPASS`, the legacy line is added to processor 0's pin. In `ST_ON_ROUTED`, the legacy line goes to the distribution core as a source request. The merged error is always driven on a separate external pin, so that a controller elsewhere can use it. The block plays no part in the legacy controller's vector-fetch cycle.

Top module: `irq_bypass_router`

## Requirements
- R1: After reset the block is disabled with pass-through set. A single enable write therefore lands in `ST_ON_BYPASS`, and the pass-through bit does not need to be written.
- R2: In `ST_ON_BYPASS`, `cpu0_irq_o` equals `legacy_irq_i` OR `core_cpu0_irq_i`, and `legacy_req_o` is 0.
- R3: In `ST_ON_ROUTED`, `legacy_req_o` equals `legacy_irq_i`, and `cpu0_irq_o` equals `core_cpu0_irq_i`.
- R4: `err_ext_o` is the OR of all bits of `err_flags_i` in every state.
- R5: `err_req_o` equals the merged error when the block is enabled, and is 0 when it is disabled.
- R6: When disabled, `cpu0_irq_o` equals the merged error, `legacy_req_o` is 0, and `legacy_irq_i` and `core_cpu0_irq_i` have no effect.
- R7: `cpu1_irq_o` equals `core_cpu1_irq_i` in every state.
- R8: `legacy_mode_o` and `err_mode_o` both read 1. The encoding is 1 = distributed delivery and 0 = direct delivery.
- R9: A control bit changes only on a clock edge where its strobe is high. It takes the value of its data input at that edge. A data input with its strobe low has no effect, and nothing changes between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we_i | input | 1 | Load strobe for the enable bit |
| en_d_i | input | 1 | New enable value |
| byp_we_i | input | 1 | Load strobe for the pass-through bit |
| byp_d_i | input | 1 | New pass-through value |
| legacy_irq_i | input | 1 | Cascaded legacy PIC interrupt (external source 0) |
| err_flags_i | input | ERR_W | Host-bridge error flags |
| core_cpu0_irq_i | input | 1 | Processor 0 interrupt from the distribution core |
| core_cpu1_irq_i | input | 1 | Processor 1 interrupt from the distribution core |
| cpu0_irq_o | output | 1 | Processor 0 interrupt pin |
| cpu1_irq_o | output | 1 | Processor 1 interrupt pin |
| legacy_req_o | output | 1 | Legacy source request to the distribution core |
| legacy_mode_o | output | 1 | Delivery mode tag of the legacy request |
| err_req_o | output | 1 | Merged error request to the distribution core |
| err_mode_o | output | 1 | Delivery mode tag of the error request |
| err_ext_o | output | 1 | Merged error for a controller elsewhere |

## Verification
Each of the four states is reached through the strobes. In each state the bench sweeps every combination of the legacy line, both core pins and all sixteen patterns of a four-flag error vector.

- The sweep distinguishes a processor 0 pin that ORs the legacy line from one that ignores it or wrongly lets it through while disabled.
- The one-hot error patterns catch a merge that drops a flag.
- Strobe-low writes and mid-cycle checks separate a registered mode change from a combinational one.
- The first enable after reset shows whether pass-through was set at reset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // bit 1 = controller enabled, bit 0 = pass-through selected
    typedef enum logic [1:0] {
        ST_OFF_ROUTED = 2'b00,
        ST_OFF_BYPASS = 2'b01,
        ST_ON_ROUTED  = 2'b10,
        ST_ON_BYPASS  = 2'b11
    } route_state_e;

    typedef enum logic {
        DLV_DIRECT  = 1'b0,
        DLV_DISTRIB = 1'b1
    } dlv_mode_e;

    localparam route_state_e RESET_STATE = ST_OFF_BYPASS;

endpackage

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_route_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we_i,
    input  logic         en_d_i,
    input  logic         byp_we_i,
    input  logic         byp_d_i,
    output route_state_e state_o
);

    route_state_e state_q;
    route_state_e state_d;
    logic         cur_en;
    logic         cur_byp;
    logic         nxt_en;
    logic         nxt_byp;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state: T_ENABLE / T_DISABLE / T_BYPASS_ON / T_BYPASS_OFF / T_BOTH / T_HOLD
    always_comb begin
        cur_en  = 1'b0;
        cur_byp = 1'b0;
        unique case (state_q)
            ST_OFF_ROUTED: begin cur_en = 1'b0; cur_byp = 1'b0; end
            ST_OFF_BYPASS: begin cur_en = 1'b0; cur_byp = 1'b1; end
            ST_ON_ROUTED:  begin cur_en = 1'b1; cur_byp = 1'b0; end
            ST_ON_BYPASS:  begin cur_en = 1'b1; cur_byp = 1'b1; end
            default:       begin cur_en = 1'b0; cur_byp = 1'b1; end
        endcase

        nxt_en  = en_we_i  ? en_d_i  : cur_en;
        nxt_byp = byp_we_i ? byp_d_i : cur_byp;

        unique case ({nxt_en, nxt_byp})
            2'b00:   state_d = ST_OFF_ROUTED;
            2'b01:   state_d = ST_OFF_BYPASS;
            2'b10:   state_d = ST_ON_ROUTED;
            default: state_d = ST_ON_BYPASS;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/irq_err_merge.sv
module irq_err_merge #(
    parameter int ERR_W = 8
) (
    input  logic [ERR_W-1:0] flags_i,
    output logic             any_o
);

    always_comb begin
        any_o = 1'b0;
        for (int i = 0; i < ERR_W; i++) begin
            any_o = any_o | flags_i[i];
        end
    end

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
    import irq_route_pkg::*;
(
    input  route_state_e state_i,
    input  logic         legacy_i,
    input  logic         core0_i,
    input  logic         core1_i,
    input  logic         err_any_i,
    output logic         cpu0_o,
    output logic         cpu1_o,
    output logic         legacy_req_o,
    output logic         err_req_o
);

    // Output process, one arm per state
    always_comb begin
        cpu1_o       = core1_i;
        cpu0_o       = 1'b0;
        legacy_req_o = 1'b0;
        err_req_o    = 1'b0;
        unique case (state_i)
            ST_OFF_ROUTED, ST_OFF_BYPASS: begin
                cpu0_o = err_any_i;
            end
            ST_ON_BYPASS: begin
                cpu0_o    = legacy_i | core0_i;
                err_req_o = err_any_i;
            end
            ST_ON_ROUTED: begin
                cpu0_o       = core0_i;
                legacy_req_o = legacy_i;
                err_req_o    = err_any_i;
            end
            default: begin
                cpu0_o = err_any_i;
            end
        endcase
    end

endmodule

// File: rtl/irq_bypass_router.sv
module irq_bypass_router
    import irq_route_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we_i,
    input  logic             en_d_i,
    input  logic             byp_we_i,
    input  logic             byp_d_i,
    input  logic             legacy_irq_i,
    input  logic [ERR_W-1:0] err_flags_i,
    input  logic             core_cpu0_irq_i,
    input  logic             core_cpu1_irq_i,
    output logic             cpu0_irq_o,
    output logic             cpu1_irq_o,
    output logic             legacy_req_o,
    output logic             legacy_mode_o,
    output logic             err_req_o,
    output logic             err_mode_o,
    output logic             err_ext_o
);

    route_state_e state;
    logic         err_any;

    irq_route_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we_i  (en_we_i),
        .en_d_i   (en_d_i),
        .byp_we_i (byp_we_i),
        .byp_d_i  (byp_d_i),
        .state_o  (state)
    );

    irq_err_merge #(.ERR_W(ERR_W)) merge_i (
        .flags_i (err_flags_i),
        .any_o   (err_any)
    );

    irq_route_mux mux_i (
        .state_i      (state),
        .legacy_i     (legacy_irq_i),
        .core0_i      (core_cpu0_irq_i),
        .core1_i      (core_cpu1_irq_i),
        .err_any_i    (err_any),
        .cpu0_o       (cpu0_irq_o),
        .cpu1_o       (cpu1_irq_o),
        .legacy_req_o (legacy_req_o),
        .err_req_o    (err_req_o)
    );

    assign err_ext_o     = err_any;
    assign legacy_mode_o = DLV_DISTRIB;
    assign err_mode_o    = DLV_DISTRIB;

endmodule

// File: rtl/irq_bypass_router_chk.sv
module irq_bypass_router_chk
    import irq_route_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_we_i,
    input logic             en_d_i,
    input logic             byp_we_i,
    input logic [ERR_W-1:0] err_flags_i,
    input logic             legacy_irq_i,
    input logic             core_cpu0_irq_i,
    input logic             core_cpu1_irq_i,
    input logic             cpu0_irq_o,
    input logic             cpu1_irq_o,
    input logic             legacy_req_o,
    input logic             legacy_mode_o,
    input logic             err_req_o,
    input logic             err_mode_o,
    input logic             err_ext_o,
    input route_state_e     state
);

    logic is_on;
    assign is_on = (state == ST_ON_BYPASS) || (state == ST_ON_ROUTED);

    assert_bypass_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON_BYPASS) |->
            (cpu0_irq_o == (legacy_irq_i | core_cpu0_irq_i)) && !legacy_req_o);

    assert_routed_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON_ROUTED) |->
            (legacy_req_o == legacy_irq_i) && (cpu0_irq_o == core_cpu0_irq_i));

    assert_err_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_ext_o == (|err_flags_i));

    assert_err_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_req_o == (is_on & err_ext_o));

    assert_off_err_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_on |-> (cpu0_irq_o == err_ext_o) && !legacy_req_o);

    assert_cpu1_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu1_irq_o == core_cpu1_irq_i);

    assert_mode_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode_o && err_mode_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_we_i && !byp_we_i) |=> $stable(state));

    assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (is_on == $past(en_d_i)));

endmodule

bind irq_bypass_router irq_bypass_router_chk #(.ERR_W(ERR_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_we_i         (en_we_i),
    .en_d_i          (en_d_i),
    .byp_we_i        (byp_we_i),
    .err_flags_i     (err_flags_i),
    .legacy_irq_i    (legacy_irq_i),
    .core_cpu0_irq_i (core_cpu0_irq_i),
    .core_cpu1_irq_i (core_cpu1_irq_i),
    .cpu0_irq_o      (cpu0_irq_o),
    .cpu1_irq_o      (cpu1_irq_o),
    .legacy_req_o    (legacy_req_o),
    .legacy_mode_o   (legacy_mode_o),
    .err_req_o       (err_req_o),
    .err_mode_o      (err_mode_o),
    .err_ext_o       (err_ext_o),
    .state           (state)
);

// File: tb/irq_bypass_router_tb_top.sv
`timescale 1ns/1ps
module irq_bypass_router_tb_top;

    localparam int ERR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_we_i = 1'b0;
    logic             en_d_i = 1'b0;
    logic             byp_we_i = 1'b0;
    logic             byp_d_i = 1'b0;
    logic             legacy_irq_i = 1'b0;
    logic [ERR_W-1:0] err_flags_i = '0;
    logic             core_cpu0_irq_i = 1'b0;
    logic             core_cpu1_irq_i = 1'b0;
    logic             cpu0_irq_o, cpu1_irq_o, legacy_req_o, legacy_mode_o;
    logic             err_req_o, err_mode_o, err_ext_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    // reference model of the two control bits
    bit  m_en   = 1'b0;
    bit  m_byp  = 1'b1;

    always #2 clk = ~clk;

    irq_bypass_router #(.ERR_W(ERR_W)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_we_i         (en_we_i),
        .en_d_i          (en_d_i),
        .byp_we_i        (byp_we_i),
        .byp_d_i         (byp_d_i),
        .legacy_irq_i    (legacy_irq_i),
        .err_flags_i     (err_flags_i),
        .core_cpu0_irq_i (core_cpu0_irq_i),
        .core_cpu1_irq_i (core_cpu1_irq_i),
        .cpu0_irq_o      (cpu0_irq_o),
        .cpu1_irq_o      (cpu1_irq_o),
        .legacy_req_o    (legacy_req_o),
        .legacy_mode_o   (legacy_mode_o),
        .err_req_o       (err_req_o),
        .err_mode_o      (err_mode_o),
        .err_ext_o       (err_ext_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b (en=%0d byp=%0d)", req, what, act, exp, m_en, m_byp);
        end
    endtask

    // Compare all outputs against the arithmetic model; cpu0 tag names the state requirement
    task automatic check_all(input string cpu0_req);
        logic e_err, e_cpu0, e_leg;
        e_err  = (err_flags_i != '0);
        e_cpu0 = !m_en ? e_err : (m_byp ? (legacy_irq_i | core_cpu0_irq_i) : core_cpu0_irq_i);
        e_leg  = m_en & !m_byp & legacy_irq_i;
        chk(cpu0_req, "cpu0_irq_o",   cpu0_irq_o,   e_cpu0);
        chk(cpu0_req, "legacy_req_o", legacy_req_o, e_leg);
        chk("R4", "err_ext_o",     err_ext_o,     e_err);
        chk("R5", "err_req_o",     err_req_o,     m_en & e_err);
        chk("R7", "cpu1_irq_o",    cpu1_irq_o,    core_cpu1_irq_i);
        chk("R8", "legacy_mode_o", legacy_mode_o, 1'b1);
        chk("R8", "err_mode_o",    err_mode_o,    1'b1);
    endtask

    function automatic string mode_req();
        if (!m_en) return "R6";
        return m_byp ? "R2" : "R3";
    endfunction

    // Drive strobes at a falling edge, let one rising edge load them (R9)
    task automatic write_ctl(input bit we_en, input bit en, input bit we_byp, input bit byp);
        @(negedge clk);
        en_we_i  = we_en;  en_d_i  = en;
        byp_we_i = we_byp; byp_d_i = byp;
        @(negedge clk);
        if (we_en)  m_en  = en;
        if (we_byp) m_byp = byp;
        en_we_i = 1'b0; byp_we_i = 1'b0;
    endtask

    task automatic sweep();
        for (int leg = 0; leg < 2; leg++)
            for (int c0 = 0; c0 < 2; c0++)
                for (int c1 = 0; c1 < 2; c1++)
                    for (int ef = 0; ef < (1 << ERR_W); ef++) begin
                        @(negedge clk);
                        legacy_irq_i    = leg[0];
                        core_cpu0_irq_i = c0[0];
                        core_cpu1_irq_i = c1[0];
                        err_flags_i     = ef[ERR_W-1:0];
                        #1 check_all(mode_req());
                    end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL ALL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R6 during reset: disabled, legacy and core0 ignored
        legacy_irq_i = 1'b1; core_cpu0_irq_i = 1'b1; err_flags_i = '0;
        #1 chk("R6", "reset cpu0 no err", cpu0_irq_o, 1'b0);
        err_flags_i = 4'b0100;
        #1 chk("R6", "reset cpu0 err", cpu0_irq_o, 1'b1);
        err_flags_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: enable only; pass-through must already be set
        write_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        legacy_irq_i = 1'b1; core_cpu0_irq_i = 1'b0;
        #1 chk("R1", "cpu0 after enable only", cpu0_irq_o, 1'b1);
        chk("R1", "legacy_req after enable only", legacy_req_o, 1'b0);

        // Exhaustive sweep in each state
        sweep();                                    // ST_ON_BYPASS
        write_ctl(1'b0, 1'b0, 1'b1, 1'b0); sweep(); // ST_ON_ROUTED
        write_ctl(1'b1, 1'b0, 1'b0, 1'b0); sweep(); // ST_OFF_ROUTED
        write_ctl(1'b0, 1'b0, 1'b1, 1'b1); sweep(); // ST_OFF_BYPASS
        write_ctl(1'b1, 1'b1, 1'b1, 1'b0); sweep(); // T_BOTH to ST_ON_ROUTED

        // R9: data with strobe low has no effect across an edge
        legacy_irq_i = 1'b1; core_cpu0_irq_i = 1'b0; err_flags_i = '0;
        write_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        #1 chk("R9", "legacy_req with strobes low", legacy_req_o, 1'b1);
        chk("R9", "cpu0 with strobes low", cpu0_irq_o, 1'b0);

        // R9: strobe high changes nothing before the edge, applies after it
        @(negedge clk);
        byp_we_i = 1'b1; byp_d_i = 1'b1;
        #1 chk("R9", "cpu0 before edge", cpu0_irq_o, 1'b0);
        chk("R9", "legacy_req before edge", legacy_req_o, 1'b1);
        @(negedge clk);
        m_byp = 1'b1; byp_we_i = 1'b0;
        #1 chk("R9", "cpu0 after edge", cpu0_irq_o, 1'b1);
        chk("R9", "legacy_req after edge", legacy_req_o, 1'b0);

        // R1: mid-run reset returns to disabled with pass-through set
        @(negedge clk);
        rst_n = 1'b0; m_en = 1'b0; m_byp = 1'b1;
        #1 chk("R1", "cpu0 in reset", cpu0_irq_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        write_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        #1 chk("R1", "cpu0 after re-enable", cpu0_irq_o, 1'b1);
        check_all("R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule